// File: doc/BRIEF.md
# Circular Signed Unit-Element Allocator

This block hands out slots from a ring of 96 bipolar current cells to the interleaved sub-registers of a converter's coarse section. Each live sub-register owns one contiguous run of cells on the ring. Every cell in that run carries the sign of its owner. On each step the caller gives two signed values. The first is the value of the sub-register being retired, which frees cells at the trailing edge of the ring. The second is the value of the sub-register being started, which claims cells at the leading edge. The cells therefore rotate through the ring in the manner of data-weighted averaging.

Two pointers give the state of the ring. The first pointer marks the oldest active cell. The second pointer marks the first free cell after the active run. A small ordered list keeps the length and sign of each live run, so the sign of every cell can be decoded directly from its distance to the first pointer. A request that would need more than the pool holds is refused as a whole. The refusal is reported on a one-cycle error output, and the state does not change.

Top module: `ues_allocator`

## Requirements
- R1: After reset, both pointers read 0, every cell control reads 00 and `err_o` is low.
- R2: Each cell has a 2-bit control at bits [2i+1:2i] of `cell_ctl_o`. The value 01 means +1, 10 means -1 and 00 means off. The value 11 never appears.
- R3: On an accepted step, `start_o` advances by |off_val_i| and `stop_o` advances by |on_val_i|, both modulo 96. A pointer whose step value is zero stays where it is.
- R4: The active cells are exactly the run that begins at `start_o` and goes upward for the number of cells currently owned. That run ends just before `stop_o`.
- R5: When `stop_o` is below `start_o`, the run wraps. The cells at or above `start_o` and the cells below `stop_o` are active, and all others are off.
- R6: Runs are laid out from `start_o` in the order they were claimed. Every cell of a run shows 01 if its owning value was positive and 10 if that value was negative.
- R7: A step is refused if the owned count after the step would exceed 96. A step is also refused if it would add a seventh live run without retiring one. A refused step changes no pointer and no cell, and `err_o` is high during the cycle that follows it.
- R8: All 96 cells may be owned at once. In that case `start_o` equals `stop_o` and every cell is active.
- R9: While `step_i` is low, the pointers and cell controls hold, whatever values are on the two value inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | Apply one retire/start step at this edge |
| off_val_i | input | 7 | Signed value of the sub-register being retired |
| on_val_i | input | 7 | Signed value of the sub-register being started |
| start_o | output | 7 | Index of the oldest active cell |
| stop_o | output | 7 | Index one past the newest active cell |
| cell_ctl_o | output | 192 | Two-bit signed control for each cell |
| err_o | output | 1 | Previous step was refused |

## Verification
The assertions assume that a nonzero retire value always names the oldest live run, with the same magnitude and the same sign. They also assume that a zero-valued sub-register never claimed cells. The bench keeps its own ordered list of the runs it has started and takes every retire value from the head of that list, so the stimulus always stays inside this assumption. Wrap, full-pool and over-demand cases are reached by choosing start values deliberately, never by feeding inconsistent retire values.

// File: rtl/ues_pkg.sv
package ues_pkg;
  typedef enum logic [1:0] {
    CTL_OFF = 2'b00,
    CTL_POS = 2'b01,
    CTL_NEG = 2'b10
  } cell_ctl_e;

  // p + n on a ring of m slots, valid for 0 <= p < m and 0 <= n <= m
  function automatic int ring_add(input int p, input int n, input int m);
    int s;
    s = p + n;
    return (s >= m) ? s - m : s;
  endfunction

  // distance walked upward from b to a on a ring of m slots
  function automatic int ring_dist(input int a, input int b, input int m);
    int d;
    d = a - b;
    return (d < 0) ? d + m : d;
  endfunction

  function automatic int mag_of(input int v);
    return (v < 0) ? -v : v;
  endfunction
endpackage

// File: rtl/ues_ptr_ring.sv
module ues_ptr_ring import ues_pkg::*; #(
  parameter int NCELL = 96,
  parameter int PW    = $clog2(NCELL),
  parameter int CW    = $clog2(NCELL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_en,
  input  logic [CW-1:0] start_step,
  input  logic [CW-1:0] stop_step,
  output logic [PW-1:0] start_q,
  output logic [PW-1:0] stop_q
);
  logic [PW-1:0] start_nx, stop_nx;

  always_comb begin
    start_nx = PW'(ring_add(int'(start_q), int'(start_step), NCELL));
    stop_nx  = PW'(ring_add(int'(stop_q), int'(stop_step), NCELL));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      stop_q  <= '0;
    end else if (adv_en) begin
      start_q <= start_nx;
      stop_q  <= stop_nx;
    end
  end

  // R3: a zero-sized retire leaves the trailing pointer in place
  assert_zero_start_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && start_step == '0) |=> $stable(start_q));

  // R3: pointers always stay inside the ring
  assert_ptr_in_ring_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(start_q) < NCELL) && (int'(stop_q) < NCELL));
endmodule

// File: rtl/ues_seg_fifo.sv
module ues_seg_fifo #(
  parameter int NSEG = 6,
  parameter int CW   = 7,
  parameter int SCW  = $clog2(NSEG + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push_en,
  input  logic                      pop_en,
  input  logic [CW-1:0]             push_len,
  input  logic                      push_neg,
  output logic [SCW-1:0]            seg_cnt,
  output logic [CW-1:0]             head_len,
  output logic                      head_neg,
  output logic [NSEG-1:0][CW-1:0]   seg_end,
  output logic [NSEG-1:0]           seg_neg
);
  localparam int IW = (NSEG > 1) ? $clog2(NSEG) : 1;

  logic [NSEG-1:0][CW-1:0] len_mem;
  logic [NSEG-1:0]         neg_mem;
  logic [IW-1:0]           head_q;
  logic [IW-1:0]           tail;

  always_comb begin
    tail = IW'((int'(head_q) + int'(seg_cnt)) % NSEG);
    head_len = len_mem[head_q];
    head_neg = neg_mem[head_q];
  end

  // runs in claim order with running end offsets measured from the start pointer
  always_comb begin
    int acc;
    int idx;
    acc = 0;
    for (int k = 0; k < NSEG; k++) begin
      idx = (int'(head_q) + k) % NSEG;
      if (k < int'(seg_cnt)) acc = acc + int'(len_mem[idx]);
      seg_end[k] = CW'(acc);
      seg_neg[k] = neg_mem[idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_mem <= '0;
      neg_mem <= '0;
      head_q  <= '0;
      seg_cnt <= '0;
    end else begin
      if (push_en) begin
        len_mem[tail] <= push_len;
        neg_mem[tail] <= push_neg;
      end
      if (pop_en) head_q <= IW'((int'(head_q) + 1) % NSEG);
      seg_cnt <= SCW'(int'(seg_cnt) + int'(push_en) - int'(pop_en));
    end
  end

  // R7: the list never holds more runs than its depth
  assert_list_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(seg_cnt) <= NSEG);

  // R6: a live run never has zero length
  assert_no_empty_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> push_len != '0);
endmodule

// File: rtl/ues_cell_map.sv
module ues_cell_map import ues_pkg::*; #(
  parameter int NCELL = 96,
  parameter int NSEG  = 6,
  parameter int PW    = $clog2(NCELL),
  parameter int CW    = $clog2(NCELL + 1),
  parameter int SCW   = $clog2(NSEG + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PW-1:0]           start_q,
  input  logic [CW-1:0]           used_q,
  input  logic [SCW-1:0]          seg_cnt,
  input  logic [NSEG-1:0][CW-1:0] seg_end,
  input  logic [NSEG-1:0]         seg_neg,
  output logic [2*NCELL-1:0]      cell_ctl
);
  logic [NCELL-1:0] cell_on;

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    logic [1:0] ctl;
    logic       on;
    always_comb begin
      int  d;
      logic neg;
      logic hit;
      d   = ring_dist(i, int'(start_q), NCELL);
      on  = d < int'(used_q);
      neg = 1'b0;
      hit = 1'b0;
      for (int k = 0; k < NSEG; k++) begin
        if (!hit && k < int'(seg_cnt) && d < int'(seg_end[k])) begin
          neg = seg_neg[k];
          hit = 1'b1;
        end
      end
      ctl = !on ? CTL_OFF : (neg ? CTL_NEG : CTL_POS);
    end
    assign cell_ctl[2*i +: 2] = ctl;
    assign cell_on[i] = on;
  end

  // R4: number of lit cells equals the owned count
  assert_active_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cell_on) == int'(used_q));
endmodule

// File: rtl/ues_allocator.sv
module ues_allocator import ues_pkg::*; #(
  parameter int NCELL = 96,
  parameter int NSEG  = 6,
  parameter int VW    = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       step_i,
  input  logic signed [VW-1:0]       off_val_i,
  input  logic signed [VW-1:0]       on_val_i,
  output logic [$clog2(NCELL)-1:0]   start_o,
  output logic [$clog2(NCELL)-1:0]   stop_o,
  output logic [2*NCELL-1:0]         cell_ctl_o,
  output logic                       err_o
);
  localparam int PW  = $clog2(NCELL);
  localparam int CW  = $clog2(NCELL + 1);
  localparam int SCW = $clog2(NSEG + 1);

  logic [CW-1:0]           off_mag, on_mag, used_q, head_len;
  logic                    head_neg;
  logic [PW-1:0]           start_q, stop_q;
  logic [SCW-1:0]          seg_cnt;
  logic [NSEG-1:0][CW-1:0] seg_end;
  logic [NSEG-1:0]         seg_neg;
  logic                    retire, claim, over_demand, list_full, reject, accept;
  logic [CW-1:0]           owned_total;
  int                      demand;

  always_comb begin
    off_mag     = CW'(mag_of(int'(off_val_i)));
    on_mag      = CW'(mag_of(int'(on_val_i)));
    retire      = off_mag != '0;
    claim       = on_mag != '0;
    demand      = int'(used_q) - int'(off_mag) + int'(on_mag);
    over_demand = (demand > NCELL) || (demand < 0);
    list_full   = claim && !retire && (int'(seg_cnt) == NSEG);
    reject      = over_demand || list_full;
    accept      = step_i && !reject;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
      err_o  <= 1'b0;
    end else begin
      err_o <= step_i && reject;
      if (accept) used_q <= CW'(demand);
    end
  end

  ues_ptr_ring #(.NCELL(NCELL), .PW(PW), .CW(CW)) u_ring (
    .clk(clk), .rst_n(rst_n), .adv_en(accept),
    .start_step(off_mag), .stop_step(on_mag),
    .start_q(start_q), .stop_q(stop_q)
  );

  ues_seg_fifo #(.NSEG(NSEG), .CW(CW), .SCW(SCW)) u_runs (
    .clk(clk), .rst_n(rst_n),
    .push_en(accept && claim), .pop_en(accept && retire),
    .push_len(on_mag), .push_neg(on_val_i[VW-1]),
    .seg_cnt(seg_cnt), .head_len(head_len), .head_neg(head_neg),
    .seg_end(seg_end), .seg_neg(seg_neg)
  );

  ues_cell_map #(.NCELL(NCELL), .NSEG(NSEG), .PW(PW), .CW(CW), .SCW(SCW)) u_map (
    .clk(clk), .rst_n(rst_n), .start_q(start_q), .used_q(used_q),
    .seg_cnt(seg_cnt), .seg_end(seg_end), .seg_neg(seg_neg),
    .cell_ctl(cell_ctl_o)
  );

  assign start_o = start_q;
  assign stop_o  = stop_q;

  always_comb begin
    owned_total = '0;
    for (int k = 0; k < NSEG; k++)
      if (k < int'(seg_cnt)) owned_total = seg_end[k];
  end

  // R4: the two pointers stay exactly the owned count apart
  assert_ring_span_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(stop_q) == ring_add(int'(start_q), int'(used_q), NCELL));

  // R6: the run list accounts for every owned cell
  assert_runs_cover_used_R6: assert property (@(posedge clk) disable iff (!rst_n)
    owned_total == used_q);

  // R3 (input assumption): a retire names the oldest live run
  assert_retire_matches_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && retire) |-> (seg_cnt != '0 && off_mag == head_len
                            && off_val_i[VW-1] == head_neg));

  // R7: a refused step leaves the state untouched
  assert_reject_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ($stable(start_q) && $stable(stop_q) && $stable(used_q)));

  // R9: no step, no movement
  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> ($stable(start_q) && $stable(stop_q) && $stable(used_q)));
endmodule

// File: tb/ues_allocator_tb.sv
module ues_allocator_tb;
  localparam int NCELL = 96;
  localparam int NSEG  = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              step_i = 1'b0;
  logic signed [6:0] off_val_i = '0;
  logic signed [6:0] on_val_i = '0;
  logic [6:0]        start_o, stop_o;
  logic [191:0]      cell_ctl_o;
  logic              err_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  int m_start = 0, m_stop = 0, m_used = 0, qn = 0;
  int q_len [NSEG];
  bit q_neg [NSEG];

  always #4 clk = ~clk;

  ues_allocator u_dut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i),
    .off_val_i(off_val_i), .on_val_i(on_val_i),
    .start_o(start_o), .stop_o(stop_o),
    .cell_ctl_o(cell_ctl_o), .err_o(err_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected cell map built by walking the runs from the start pointer
  task automatic check_cells();
    int exp_c [NCELL];
    int pos, bad_enc, bad_act, bad_sgn, c_enc, c_act, c_sgn;
    string rq;
    for (int c = 0; c < NCELL; c++) exp_c[c] = 0;
    pos = m_start;
    for (int s = 0; s < qn; s++)
      for (int j = 0; j < q_len[s]; j++) begin
        exp_c[pos] = q_neg[s] ? 2 : 1;
        pos = (pos + 1) % NCELL;
      end
    bad_enc = -1; bad_act = -1; bad_sgn = -1;
    for (int c = 0; c < NCELL; c++) begin
      int a;
      a = int'(cell_ctl_o[2*c +: 2]);
      if (a == 3 && bad_enc < 0) begin bad_enc = c; c_enc = a; end
      if (((a != 0) != (exp_c[c] != 0)) && bad_act < 0) begin bad_act = c; c_act = a; end
      if (a != 0 && exp_c[c] != 0 && a != exp_c[c] && bad_sgn < 0) begin bad_sgn = c; c_sgn = a; end
    end
    rq = (m_stop < m_start) ? "R5" : "R4";
    chk("R2", "no 11 code", (bad_enc < 0) ? 0 : c_enc, 0);
    chk(rq, $sformatf("active set (first bad cell %0d)", bad_act),
        (bad_act < 0) ? 0 : c_act, (bad_act < 0) ? 0 : exp_c[bad_act]);
    chk("R6", $sformatf("cell sign (first bad cell %0d)", bad_sgn),
        (bad_sgn < 0) ? 0 : c_sgn, (bad_sgn < 0) ? 0 : exp_c[bad_sgn]);
  endtask

  task automatic step_q(input bit pop_it, input int newv);
    int offv, offm, onm, dem;
    bit rej;
    offv = 0;
    if (pop_it && qn > 0) offv = q_neg[0] ? -q_len[0] : q_len[0];
    @(negedge clk);
    step_i = 1'b1; off_val_i = 7'(offv); on_val_i = 7'(newv);
    @(negedge clk);
    step_i = 1'b0; off_val_i = '0; on_val_i = '0;
    offm = (offv < 0) ? -offv : offv;
    onm  = (newv < 0) ? -newv : newv;
    dem  = m_used - offm + onm;
    rej  = (dem > NCELL) || (onm != 0 && offm == 0 && qn == NSEG);
    if (!rej) begin
      m_start = (m_start + offm) % NCELL;
      m_stop  = (m_stop + onm) % NCELL;
      m_used  = dem;
      if (offm != 0) begin
        for (int s = 0; s < NSEG - 1; s++) begin q_len[s] = q_len[s+1]; q_neg[s] = q_neg[s+1]; end
        qn--;
      end
      if (onm != 0) begin q_len[qn] = onm; q_neg[qn] = newv < 0; qn++; end
    end
    chk("R7", "err_o", int'(err_o), int'(rej));
    chk("R3", "start_o", int'(start_o), m_start);
    chk("R3", "stop_o", int'(stop_o), m_stop);
    check_cells();
  endtask

  task automatic drain();
    while (qn > 0) step_q(1'b1, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "start after reset", int'(start_o), 0);
    chk("R1", "stop after reset", int'(stop_o), 0);
    chk("R1", "err after reset", int'(err_o), 0);
    chk("R1", "cells after reset", (cell_ctl_o == '0) ? 0 : 1, 0);
  endtask

  task automatic t_basic();
    step_q(1'b0, 5);
    step_q(1'b0, -3);
    step_q(1'b1, 0);
    step_q(1'b0, 0);
  endtask

  task automatic t_idle();
    logic [6:0] s0, p0;
    logic [191:0] c0;
    s0 = start_o; p0 = stop_o; c0 = cell_ctl_o;
    @(negedge clk);
    off_val_i = 7'sd9; on_val_i = -7'sd12;
    repeat (3) @(negedge clk);
    chk("R9", "start idle", int'(start_o), int'(s0));
    chk("R9", "stop idle", int'(stop_o), int'(p0));
    chk("R9", "cells idle", (cell_ctl_o == c0) ? 0 : 1, 0);
    off_val_i = '0; on_val_i = '0;
  endtask

  task automatic t_rotate();
    for (int i = 0; i < 40; i++) step_q(qn >= 4, ((i * 13) % 41) - 20);
  endtask

  task automatic t_full_pool();
    drain();
    step_q(1'b0, 30);
    step_q(1'b1, 0);
    step_q(1'b0, -64);
    step_q(1'b0, 32);
    chk("R8", "start equals stop when full", int'(start_o), int'(stop_o));
    chk("R8", "all cells lit", $countones(cell_ctl_o), NCELL);
    step_q(1'b0, 1);
    step_q(1'b0, -1);
    step_q(1'b1, 5);
    drain();
  endtask

  task automatic t_list_full();
    for (int i = 0; i < NSEG; i++) step_q(1'b0, (i % 2) ? -1 : 2);
    step_q(1'b0, 3);
    step_q(1'b1, -4);
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_idle();
    t_rotate();
    t_full_pool();
    t_list_full();
    t_rotate();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule